// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the software-visible register set of an ECC memory controller. It holds nine 32-bit word registers behind a simple synchronous bus. The bus has a byte address, a write enable, write data and a read-data return. Reads are combinational on the address, and writes take effect at the clock edge. A static `VARIANT` parameter picks one of three controller flavours, coded 0, 1 and 2. The flavour is stored in the top nibble of the enable register. It sets the enable-register write mask, which enable bits survive a warm reset, and whether a 4-byte diagnostic window is present.

The memory datapath reports a detected fault through a capture strobe that carries a status word and two address words. The capture loads the fault status register and both fault address registers and raises the interrupt line. The interrupt stays high until software writes the fault status register. Two resets exist. The asynchronous power-on reset `rstN` loads the flavour code and every reset value. The synchronous `warmRst` also restores the reset values, but it preserves a flavour-dependent set of enable-register bits.

Top module: `ecc_ctl_regs`

## Requirements
- R1: After power-on reset, the enable register (word 0) reads VARIANT<<28, the delay register (word 1) reads 0x00000020, fault address 0 (word 4) reads 0x07C00000, every other word reads 0, and irq is low.
- R2: A write to word 0 stores write data AND 0x00000103 when VARIANT is 0. For VARIANT 1 or 2 it stores (VARIANT<<28) OR (write data AND 0x00000BFF).
- R3: A write to word 1 stores write data AND 0x7FFFFFFF, so bit 31 always reads 0.
- R4: A write to the fault status register (word 2) stores the full 32-bit value and drives irq low from the next cycle, unless a capture happens in the same cycle.
- R5: Bus writes to fault address 0 and 1 (words 4 and 5) are ignored. These registers change only on capture or reset.
- R6: While warmRst is high at a clock edge, the enable register keeps only bit 8 (VARIANT 0) or only bits 31:24, 11 and 9:2 (VARIANT 1/2). All other registers take their R1 values, diagnostic bytes clear and irq goes low.
- R7: Words 3, 6, 7 and 8 are plain 32-bit read/write registers. Word 7 and word 8 are distinct storage.
- R8: Word offsets 9 to 15 read as 0, and writes to them change no register.
- R9: errStrobe high at a clock edge loads errStatus into word 2 and errAddr0/errAddr1 into words 4/5, and sets irq from the next cycle. irq then holds until a status write or reset. A capture wins over a status write in the same cycle.
- R10: With diagSel high and VARIANT 0, a write stores wrData[7:0] into diagnostic byte addr[1:0], and a read returns that byte zero-extended. The register file is untouched. With VARIANT 1/2, diagnostic reads return 0 and writes do nothing.
- R11: rdData reflects the register selected by the current addr and diagSel in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| warmRst | input | 1 | Synchronous warm reset, active high |
| addr | input | ADDR_W | Byte address; bits above 1 pick the word, bits 1:0 pick the diagnostic byte |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| diagSel | input | 1 | Routes the access to the diagnostic byte window |
| rdData | output | 32 | Combinational read data |
| errStrobe | input | 1 | Fault capture strobe |
| errStatus | input | 32 | Fault status value to capture |
| errAddr0 | input | 32 | First fault address word to capture |
| errAddr1 | input | 32 | Second fault address word to capture |
| irq | output | 1 | Fault interrupt, level |

## Verification
Every register is visible on rdData in the same cycle, so a wrong stored value or a wrong mask shows up on the first read after the write. That read is one clock after the write edge. A bad decode shows up as a neighbouring word changing, because each write is followed by a read of all sixteen offsets. A wrong interrupt state shows at the irq pin one cycle after the capture or status write that should have changed it. Errors in flavour-dependent behaviour appear when the same stimulus is applied to a variant-0 instance and a variant-1 instance side by side.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 9;
  localparam int DIAG_BYTES = 4;
  localparam int BYTE_W     = 8;
  localparam int DIAG_IDX_W = $clog2(DIAG_BYTES);
  localparam int VER_LSB    = 28;

  // word offsets; the order is the software-visible map
  localparam int OFF_ENABLE = 0;
  localparam int OFF_DELAY  = 1;
  localparam int OFF_STATUS = 2;
  localparam int OFF_VIDEO  = 3;
  localparam int OFF_FADDR0 = 4;
  localparam int OFF_FADDR1 = 5;
  localparam int OFF_DIAG   = 6;
  localparam int OFF_ECTL0  = 7;
  localparam int OFF_ECTL1  = 8;

  localparam logic [DATA_W-1:0] DELAY_MASK = 32'h7FFF_FFFF;
  localparam logic [DATA_W-1:0] DELAY_RST  = 32'h0000_0020;
  localparam logic [DATA_W-1:0] FADDR0_RST = 32'h07C0_0000;

  // strobes from the decoder to the register storage
  typedef struct packed {
    logic [NUM_REGS-1:0]   wrHit;
    logic [NUM_REGS-1:0]   rdHit;
    logic                  diagWr;
    logic                  diagRd;
    logic [DIAG_IDX_W-1:0] byteIdx;
  } ctlStrobeT;

  function automatic logic [DATA_W-1:0] enableWrMask(input logic [3:0] ver);
    return (ver == 4'd0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [DATA_W-1:0] enableKeepMask(input logic [3:0] ver);
    // flavour 0: bit 8; others: version/impl nibbles, bit 11, refresh field 9:2
    return (ver == 4'd0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

endpackage

// File: rtl/ecc_regs_ctrl.sv
module ecc_regs_ctrl
  import ecc_regs_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int unsigned VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              diagSel,
  output ctlStrobeT         strb
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam bit HAS_DIAG = (VARIANT == 0);

  logic [IDX_W-1:0]    wordIdx;
  logic [NUM_REGS-1:0] rdHitV;
  logic [NUM_REGS-1:0] wrHitV;
  logic                diagWrV;
  logic                diagRdV;

  assign wordIdx = addr[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam bit WRITABLE = (i != OFF_FADDR0) && (i != OFF_FADDR1);
    assign rdHitV[i] = !diagSel && (wordIdx == IDX_W'(i));
    if (WRITABLE) begin : g_wr
      assign wrHitV[i] = wrEn && rdHitV[i];
    end else begin : g_ro
      assign wrHitV[i] = 1'b0;
    end
  end

  if (HAS_DIAG) begin : g_diag
    assign diagWrV = wrEn && diagSel;
    assign diagRdV = diagSel;
  end else begin : g_nodiag
    assign diagWrV = 1'b0;
    assign diagRdV = 1'b0;
  end

  assign strb = '{wrHit:   wrHitV,
                  rdHit:   rdHitV,
                  diagWr:  diagWrV,
                  diagRd:  diagRdV,
                  byteIdx: addr[DIAG_IDX_W-1:0]};

  // R8: at most one storage element is written per cycle
  p_single_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrHit, strb.diagWr}));

  // R10: a diagnostic access never also selects a register word
  p_diag_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    diagSel |-> (strb.rdHit == '0));

endmodule

// File: rtl/ecc_regs_dp.sv
module ecc_regs_dp
  import ecc_regs_pkg::*;
#(
  parameter int unsigned VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              warmRst,
  input  ctlStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              errStrobe,
  input  logic [DATA_W-1:0] errStatus,
  input  logic [DATA_W-1:0] errAddr0,
  input  logic [DATA_W-1:0] errAddr1,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam logic [3:0]        VER_CODE    = 4'(VARIANT);
  localparam logic [DATA_W-1:0] VER_WORD    = {VER_CODE, {VER_LSB{1'b0}}};
  localparam logic [DATA_W-1:0] ENABLE_WMSK = enableWrMask(VER_CODE);
  localparam logic [DATA_W-1:0] ENABLE_KEEP = enableKeepMask(VER_CODE);
  localparam bit                HAS_DIAG    = (VARIANT == 0);

  logic [DATA_W-1:0] regEnable, regDelay, regStatus, regVideo;
  logic [DATA_W-1:0] regFaddr0, regFaddr1, regDiag, regEctl0, regEctl1;
  logic              irqQ;
  logic [BYTE_W-1:0] diagByte [DIAG_BYTES];
  logic [DATA_W-1:0] regView  [NUM_REGS];
  logic [DATA_W-1:0] regMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regEnable <= VER_WORD;
      regDelay  <= DELAY_RST;
      regStatus <= '0;
      regVideo  <= '0;
      regFaddr0 <= FADDR0_RST;
      regFaddr1 <= '0;
      regDiag   <= '0;
      regEctl0  <= '0;
      regEctl1  <= '0;
      irqQ      <= 1'b0;
    end else if (warmRst) begin
      regEnable <= regEnable & ENABLE_KEEP;
      regDelay  <= DELAY_RST;
      regStatus <= '0;
      regVideo  <= '0;
      regFaddr0 <= FADDR0_RST;
      regFaddr1 <= '0;
      regDiag   <= '0;
      regEctl0  <= '0;
      regEctl1  <= '0;
      irqQ      <= 1'b0;
    end else begin
      if (strb.wrHit[OFF_ENABLE]) regEnable <= VER_WORD | (wrData & ENABLE_WMSK);
      if (strb.wrHit[OFF_DELAY])  regDelay  <= wrData & DELAY_MASK;
      if (strb.wrHit[OFF_VIDEO])  regVideo  <= wrData;
      if (strb.wrHit[OFF_DIAG])   regDiag   <= wrData;
      if (strb.wrHit[OFF_ECTL0])  regEctl0  <= wrData;
      if (strb.wrHit[OFF_ECTL1])  regEctl1  <= wrData;
      if (errStrobe) begin
        regStatus <= errStatus;
        regFaddr0 <= errAddr0;
        regFaddr1 <= errAddr1;
        irqQ      <= 1'b1;
      end else if (strb.wrHit[OFF_STATUS]) begin
        regStatus <= wrData;
        irqQ      <= 1'b0;
      end
    end
  end

  if (HAS_DIAG) begin : g_diag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int b = 0; b < DIAG_BYTES; b++) diagByte[b] <= '0;
      end else if (warmRst) begin
        for (int b = 0; b < DIAG_BYTES; b++) diagByte[b] <= '0;
      end else if (strb.diagWr) begin
        diagByte[strb.byteIdx] <= wrData[BYTE_W-1:0];
      end
    end
  end else begin : g_nodiag
    for (genvar b = 0; b < DIAG_BYTES; b++) begin : g_zero
      assign diagByte[b] = '0;
    end
  end

  always_comb begin
    regView[OFF_ENABLE] = regEnable;
    regView[OFF_DELAY]  = regDelay;
    regView[OFF_STATUS] = regStatus;
    regView[OFF_VIDEO]  = regVideo;
    regView[OFF_FADDR0] = regFaddr0;
    regView[OFF_FADDR1] = regFaddr1;
    regView[OFF_DIAG]   = regDiag;
    regView[OFF_ECTL0]  = regEctl0;
    regView[OFF_ECTL1]  = regEctl1;
  end

  always_comb begin
    regMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.rdHit[i]) regMux = regMux | regView[i];
    end
  end

  assign rdData = strb.diagRd ? {{(DATA_W-BYTE_W){1'b0}}, diagByte[strb.byteIdx]} : regMux;
  assign irq    = irqQ;

  // R9: a capture raises the interrupt on the next cycle
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errStrobe && !warmRst) |=> irq);

  // R9: the interrupt holds until a status write or warm reset
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strb.wrHit[OFF_STATUS] && !warmRst) |=> irq);

  // R4: a status write without capture drops the interrupt
  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHit[OFF_STATUS] && !errStrobe && !warmRst) |=> !irq);

  // R5: fault addresses move only on capture or reset
  p_faddr_ro_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!errStrobe && !warmRst) |=> ($stable(regFaddr0) && $stable(regFaddr1)));

  // R3: a delay write leaves bit 31 clear
  p_delay_msb_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHit[OFF_DELAY] && !warmRst) |=> !regDelay[DATA_W-1]);

  // R6: warm reset restores the delay and fault address values
  p_warm_vals_r6: assert property (@(posedge clk) disable iff (!rstN)
    warmRst |=> (regDelay == DELAY_RST && regFaddr0 == FADDR0_RST && !irq));

  // R2: the flavour code is never lost from the enable register
  p_ver_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    regEnable[DATA_W-1:VER_LSB] == VER_CODE);

endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
  import ecc_regs_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int unsigned VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              warmRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              diagSel,
  output logic [31:0]       rdData,
  input  logic              errStrobe,
  input  logic [31:0]       errStatus,
  input  logic [31:0]       errAddr0,
  input  logic [31:0]       errAddr1,
  output logic              irq
);

  ctlStrobeT strb;

  ecc_regs_ctrl #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .diagSel (diagSel),
    .strb    (strb)
  );

  ecc_regs_dp #(.VARIANT(VARIANT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .warmRst   (warmRst),
    .strb      (strb),
    .wrData    (wrData),
    .errStrobe (errStrobe),
    .errStatus (errStatus),
    .errAddr0  (errAddr0),
    .errAddr1  (errAddr1),
    .rdData    (rdData),
    .irq       (irq)
  );

endmodule

// File: tb/ecc_ctl_regs_tb.sv
`timescale 1ns/1ps
module ecc_ctl_regs_tb;

  localparam int ADDR_W = 6;
  localparam int NWORDS = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              warmRst = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [31:0]       wrData = '0;
  logic              diagSel = 1'b0;
  logic              errStrobe = 1'b0;
  logic [31:0]       errStatus = '0, errAddr0 = '0, errAddr1 = '0;
  logic [31:0]       rdData0, rdData1;
  logic              irq0, irq1;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  logic [31:0] mReg [2][9];
  logic [7:0]  mDiag [4];
  logic        mIrq;

  always #2 clk = ~clk;

  ecc_ctl_regs #(.ADDR_W(ADDR_W), .VARIANT(0)) u_dut (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .diagSel(diagSel), .rdData(rdData0), .errStrobe(errStrobe),
    .errStatus(errStatus), .errAddr0(errAddr0), .errAddr1(errAddr1), .irq(irq0));

  ecc_ctl_regs #(.ADDR_W(ADDR_W), .VARIANT(1)) u_dut_v1 (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .diagSel(diagSel), .rdData(rdData1), .errStrobe(errStrobe),
    .errStatus(errStatus), .errAddr0(errAddr0), .errAddr1(errAddr1), .irq(irq1));

  function automatic logic [31:0] verWord(int v);
    return 32'(v) << 28;
  endfunction

  function automatic logic [31:0] keepMask(int v);
    if (v == 0) return 32'h1 << 8;
    return 32'hFF00_0000 | (32'h1 << 11) | (32'hFF << 2);
  endfunction

  function automatic string reqOf(int off);
    case (off)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      4, 5: return "R5";
      3, 6, 7, 8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelReset(bit warm);
    for (int v = 0; v < 2; v++) begin
      mReg[v][0] = warm ? (mReg[v][0] & keepMask(v)) : verWord(v);
      mReg[v][1] = 32'h20;
      mReg[v][4] = 32'h07C0_0000;
      for (int r = 2; r < 9; r++) if (r != 4) mReg[v][r] = '0;
    end
    for (int b = 0; b < 4; b++) mDiag[b] = '0;
    mIrq = 1'b0;
  endtask

  task automatic modelWrite(int off, logic [31:0] d);
    for (int v = 0; v < 2; v++) begin
      case (off)
        0: mReg[v][0] = (v == 0) ? (d & 32'h103) : (verWord(v) | (d & 32'hBFF));
        1: mReg[v][1] = d & ~(32'h1 << 31);
        2: mReg[v][2] = d;
        3, 6, 7, 8: mReg[v][off] = d;
        default: ;
      endcase
    end
    if (off == 2) mIrq = 1'b0;
  endtask

  task automatic busWrite(int off, logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(off * 4); wrData = d; wrEn = 1'b1; diagSel = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(off, d);
  endtask

  task automatic readCheck(int off, string req);
    logic [31:0] e0, e1;
    @(negedge clk);
    addr = ADDR_W'(off * 4); diagSel = 1'b0;
    #1;
    e0 = (off < 9) ? mReg[0][off] : '0;
    e1 = (off < 9) ? mReg[1][off] : '0;
    check(req, rdData0, e0, $sformatf("variant0 word %0d", off));
    check(req, rdData1, e1, $sformatf("variant1 word %0d", off));
  endtask

  task automatic checkAll(string override);
    for (int off = 0; off < NWORDS; off++)
      readCheck(off, (override == "") ? reqOf(off) : override);
  endtask

  task automatic checkIrq(string req);
    #1;
    check(req, {31'b0, irq0}, {31'b0, mIrq}, "irq variant0");
    check(req, {31'b0, irq1}, {31'b0, mIrq}, "irq variant1");
  endtask

  task automatic capture(logic [31:0] s, logic [31:0] a0, logic [31:0] a1, bit alsoWrite);
    @(negedge clk);
    errStatus = s; errAddr0 = a0; errAddr1 = a1; errStrobe = 1'b1;
    if (alsoWrite) begin addr = ADDR_W'(2 * 4); wrData = ~s; wrEn = 1'b1; end
    @(negedge clk);
    errStrobe = 1'b0; wrEn = 1'b0;
    for (int v = 0; v < 2; v++) begin
      mReg[v][2] = s; mReg[v][4] = a0; mReg[v][5] = a1;
    end
    mIrq = 1'b1;
  endtask

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5A5A;

    modelReset(1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: power-on values
    checkAll("R1");
    @(negedge clk); checkIrq("R1");

    // R11: two addresses inside one low clock phase
    @(negedge clk);
    addr = ADDR_W'(1 * 4); #0.5;
    check("R11", rdData0, 32'h20, "same-cycle read word 1");
    addr = ADDR_W'(4 * 4); #0.5;
    check("R11", rdData0, 32'h07C0_0000, "same-cycle read word 4");

    // write sweep over every offset and pattern; R2 R3 R5 R7 R8
    for (int p = 0; p < 3; p++) begin
      for (int off = 0; off < NWORDS; off++) begin
        busWrite(off, pats[p] ^ (32'h0101_0101 * off));
        checkAll("");
      end
    end

    // R9: capture loads status and addresses and raises irq
    capture(32'hDEAD_0001, 32'h1234_5678, 32'h8765_4321, 1'b0);
    checkIrq("R9");
    checkAll("R9");
    @(negedge clk); checkIrq("R9");
    // R4: status write clears irq
    busWrite(2, 32'h0000_00F0);
    checkIrq("R4");
    readCheck(2, "R4");
    // R9: capture beats a same-cycle status write
    capture(32'hC0DE_0002, 32'h0000_0ABC, 32'hFFFF_0000, 1'b1);
    checkIrq("R9");
    readCheck(2, "R9");
    // R5: writes to fault addresses leave them and irq alone
    busWrite(4, 32'h0);
    busWrite(5, 32'h0);
    readCheck(4, "R5"); readCheck(5, "R5");
    checkIrq("R5");

    // R10: diagnostic byte window
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      addr = ADDR_W'(b); diagSel = 1'b1; wrData = 32'hABCD_EF00 | (32'h11 * (b + 1)); wrEn = 1'b1;
      @(negedge clk);
      wrEn = 1'b0;
      mDiag[b] = 8'(32'h11 * (b + 1));
    end
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      addr = ADDR_W'(b); diagSel = 1'b1; #1;
      check("R10", rdData0, {24'b0, mDiag[b]}, $sformatf("diag byte %0d variant0", b));
      check("R10", rdData1, 32'h0, $sformatf("diag byte %0d variant1", b));
    end
    @(negedge clk); diagSel = 1'b0;
    checkAll("R10");

    // R6: warm reset preservation
    busWrite(0, 32'hFFFF_FFFF);
    busWrite(7, 32'h5555_AAAA);
    @(negedge clk); warmRst = 1'b1;
    @(negedge clk); warmRst = 1'b0;
    modelReset(1'b1);
    checkAll("R6");
    checkIrq("R6");
    @(negedge clk);
    addr = ADDR_W'(1); diagSel = 1'b1; #1;
    check("R6", rdData0, 32'h0, "diag byte after warm reset");
    diagSel = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule